// File: doc/BRIEF.md
# Single-Precision Float to Unsigned Integer Truncating Converter

This block takes one IEEE-754 single-precision operand per strobe and, one clock later, returns its value as a 32-bit unsigned integer. The fraction is always dropped, so the conversion rounds toward zero. Alongside the integer it reports an invalid-operation flag, an inexact flag and a clear indication. The clear indication tells the surrounding status logic that this conversion raised no flag and the flag field may be zeroed.

The sign of the operand is examined before any truncation. A negative operand is therefore rejected even when its magnitude is too small to survive truncation. The only exception is negative zero. NaNs never leak an all-ones pattern: they always give zero. Positive operands at or above 2^32 clamp to the largest unsigned value. At most one flag is raised per conversion, and invalid always takes precedence over inexact.

Top module: `f2u_trunc_conv`

## Requirements
- R1: For a positive normal operand with value v where 1.0 <= v < 2^32, the result is floor(v), i.e. the integer part with all fraction bits discarded.
- R2: An operand with exponent field (bits 30:23) all ones and a nonzero mantissa field (bits 22:0), which is any NaN, gives result 0 with invalid set.
- R3: An operand with sign bit 31 set and bits 30:0 nonzero gives result 0 with invalid set. This covers negative subnormals, negative values of magnitude below 1 (e.g. 0x836D4E86) and negative infinity.
- R4: +0 (0x00000000) and -0 (0x80000000) give result 0 with neither flag set.
- R5: A positive operand whose value is 2^32 or more (encoding 0x4F800000 and above, including +infinity 0x7F800000) gives result 0xFFFFFFFF with invalid set.
- R6: Invalid and inexact are never both set. Whenever invalid is set, inexact is low.
- R7: For a positive finite operand below 2^32, inexact is set exactly when nonzero fraction bits were discarded. A positive subnormal or a positive value below 1.0 therefore gives result 0 with inexact set.
- R8: The clear output is set for a conversion exactly when neither invalid nor inexact is set for it.
- R9: Result, flags and clear are registered on the clock edge that samples the input strobe, and the output valid follows the strobe by one cycle. Without a strobe these outputs hold their values. A synchronous active-low reset sets all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Operand strobe |
| in_op | input | 32 | Single-precision operand |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| out_res | output | 32 | Truncated unsigned integer |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_clr | output | 1 | No flag raised for this conversion |

## Verification
The bench targets the ordering corners. A tiny negative operand such as 0x836D4E86 must be flagged invalid; a design that truncates before checking the sign would return a clean zero. Negative zero must stay flag-free; a design that tests only the sign bit would mark it invalid. NaN payloads with both quiet and signalling patterns are applied to catch a design that saturates NaNs to all ones. The operands around the 2^32 threshold (0x4F7FFFFF, 0x4F800000) and around 1.0 expose off-by-one errors in the exponent compare. Random operands spread over every exponent value catch a shifter that loses or keeps the wrong fraction bits, which would show up as a wrong integer or a wrong inexact flag.

// File: rtl/f2u_pkg.sv
// Shared types for the float-to-unsigned truncating converter.
// Assumes: one operand class per input; the class set does not depend on width.
package f2u_pkg;

    // Operand classes produced by the unpacker
    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_SUB  = 3'd1,
        CLS_NORM = 3'd2,
        CLS_INF  = 3'd3,
        CLS_NAN  = 3'd4
    } f2u_cls_e;

    // Exception flags of one conversion
    typedef struct packed {
        logic invalid;
        logic inexact;
    } f2u_flags_t;

endpackage

// File: rtl/f2u_unpack.sv
// Splits a binary floating-point operand into sign, biased exponent and
// significand (hidden bit restored for normals), and classifies it.
// Assumes: IEEE-754 style layout {sign, exponent, mantissa}; purely combinational.
module f2u_unpack
    import f2u_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int FLT_W = 1 + EXP_W + MAN_W
) (
    input  logic [FLT_W-1:0] op,
    output logic             sign,
    output logic [EXP_W-1:0] exp,
    output logic [MAN_W:0]   sig,
    output f2u_cls_e         cls
);

    logic [MAN_W-1:0] frac;
    logic             exp_max;
    logic             exp_min;
    logic             frac_nz;

    // Field extraction
    always_comb begin
        sign    = op[FLT_W-1];
        exp     = op[FLT_W-2 -: EXP_W];
        frac    = op[MAN_W-1:0];
        exp_max = &exp;
        exp_min = ~|exp;
        frac_nz = |frac;
    end

    // Significand with hidden bit: set only for normal numbers
    always_comb begin
        sig = {~exp_min, frac};
    end

    // Operand classification
    always_comb begin
        if (exp_max)
            cls = frac_nz ? CLS_NAN : CLS_INF;
        else if (exp_min)
            cls = frac_nz ? CLS_SUB : CLS_ZERO;
        else
            cls = CLS_NORM;
    end

endmodule

// File: rtl/f2u_trunc_shift.sv
// Aligns a normal significand to the integer binary point by a left shift of
// (exponent - bias), keeps the integer part and reports whether any set
// fraction bit was dropped. Also reports range: below one, or beyond INT_W bits.
// Assumes: the caller only uses the integer/lost outputs when the exponent is
// in range; out-of-range cases are resolved downstream.
module f2u_trunc_shift #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32,
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1,
    localparam int SH_W  = $clog2(INT_W),
    localparam int EXT_W = INT_W + MAN_W + 1
) (
    input  logic [EXP_W-1:0] exp,
    input  logic [MAN_W:0]   sig,
    output logic [INT_W-1:0] int_val,
    output logic             frac_lost,
    output logic             below_one,
    output logic             too_big
);

    localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] EXP_OVF = EXP_W'(BIAS + INT_W);

    logic [EXP_W-1:0] unb;
    logic [SH_W-1:0]  sh;
    logic [EXT_W-1:0] ext;

    // Range decisions on the biased exponent
    always_comb begin
        below_one = (exp < EXP_ONE);
        too_big   = (exp >= EXP_OVF);
    end

    // Shift amount, valid only when exponent is in range
    always_comb begin
        unb = exp - EXP_ONE;
        sh  = (below_one || too_big) ? '0 : unb[SH_W-1:0];
    end

    // Align significand: integer part above MAN_W, fraction below
    always_comb begin
        ext       = EXT_W'(sig) << sh;
        int_val   = ext[MAN_W +: INT_W];
        frac_lost = |ext[MAN_W-1:0];
    end

endmodule

// File: rtl/f2u_flag_arb.sv
// Chooses the final integer and the single exception flag from the operand
// class, its sign and the shifter's range outputs. The sign is judged before
// truncation: any negative nonzero operand is invalid. Invalid masks inexact.
// Assumes: shifter outputs are meaningful only for CLS_NORM.
module f2u_flag_arb
    import f2u_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic             sign,
    input  f2u_cls_e         cls,
    input  logic [INT_W-1:0] int_val,
    input  logic             frac_lost,
    input  logic             below_one,
    input  logic             too_big,
    output logic [INT_W-1:0] res,
    output f2u_flags_t       flags,
    output logic             clr
);

    localparam logic [INT_W-1:0] SAT_MAX = '1;

    f2u_flags_t raw;

    // Result and raw flag selection per class
    always_comb begin
        res = '0;
        raw = '{invalid: 1'b0, inexact: 1'b0};
        unique case (cls)
            CLS_NAN: begin
                raw.invalid = 1'b1;
            end
            CLS_INF: begin
                raw.invalid = 1'b1;
                res         = sign ? '0 : SAT_MAX;
            end
            CLS_ZERO: begin
                res = '0;
            end
            CLS_SUB: begin
                if (sign) raw.invalid = 1'b1;
                else      raw.inexact = 1'b1;
            end
            CLS_NORM: begin
                if (sign) begin
                    raw.invalid = 1'b1;
                end else if (too_big) begin
                    raw.invalid = 1'b1;
                    res         = SAT_MAX;
                end else if (below_one) begin
                    raw.inexact = 1'b1;
                end else begin
                    res         = int_val;
                    raw.inexact = frac_lost;
                end
            end
            default: begin
                raw.invalid = 1'b1;
            end
        endcase
    end

    // One-flag rule: invalid wins over inexact
    always_comb begin
        flags.invalid = raw.invalid;
        flags.inexact = raw.inexact & ~raw.invalid;
        clr           = ~(flags.invalid | flags.inexact);
    end

endmodule

// File: rtl/f2u_trunc_conv.sv
// Float-to-unsigned converter with round-toward-zero and a single-cycle
// registered output. Unpack -> truncating shift -> flag arbitration -> register.
// Assumes: one operand per in_vld; outputs hold when no strobe arrives;
// synchronous active-low reset.
module f2u_trunc_conv
    import f2u_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32,
    localparam int FLT_W = 1 + EXP_W + MAN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [FLT_W-1:0] in_op,
    output logic             out_vld,
    output logic [INT_W-1:0] out_res,
    output logic             out_invalid,
    output logic             out_inexact,
    output logic             out_clr
);

    logic             u_sign;
    logic [EXP_W-1:0] u_exp;
    logic [MAN_W:0]   u_sig;
    f2u_cls_e         u_cls;

    logic [INT_W-1:0] s_int;
    logic             s_lost;
    logic             s_below;
    logic             s_big;

    logic [INT_W-1:0] a_res;
    f2u_flags_t       a_flags;
    logic             a_clr;

    f2u_unpack #(
        .EXP_W (EXP_W),
        .MAN_W (MAN_W)
    ) u_unpack (
        .op   (in_op),
        .sign (u_sign),
        .exp  (u_exp),
        .sig  (u_sig),
        .cls  (u_cls)
    );

    f2u_trunc_shift #(
        .EXP_W (EXP_W),
        .MAN_W (MAN_W),
        .INT_W (INT_W)
    ) u_shift (
        .exp       (u_exp),
        .sig       (u_sig),
        .int_val   (s_int),
        .frac_lost (s_lost),
        .below_one (s_below),
        .too_big   (s_big)
    );

    f2u_flag_arb #(
        .INT_W (INT_W)
    ) u_arb (
        .sign      (u_sign),
        .cls       (u_cls),
        .int_val   (s_int),
        .frac_lost (s_lost),
        .below_one (s_below),
        .too_big   (s_big),
        .res       (a_res),
        .flags     (a_flags),
        .clr       (a_clr)
    );

    // Output valid tracks the input strobe by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= in_vld;
    end

    // Capture result and flags on a strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_res     <= '0;
            out_invalid <= 1'b0;
            out_inexact <= 1'b0;
            out_clr     <= 1'b0;
        end else if (in_vld) begin
            out_res     <= a_res;
            out_invalid <= a_flags.invalid;
            out_inexact <= a_flags.inexact;
            out_clr     <= a_clr;
        end
    end

endmodule

// File: rtl/f2u_trunc_conv_chk.sv
// Protocol and corner-case properties for f2u_trunc_conv, bound to the top.
// Assumes: same parameters as the bound instance.
module f2u_trunc_conv_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32,
    localparam int FLT_W = 1 + EXP_W + MAN_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic [FLT_W-1:0] in_op,
    input logic             out_vld,
    input logic [INT_W-1:0] out_res,
    input logic             out_invalid,
    input logic             out_inexact,
    input logic             out_clr
);

    logic past_ok;

    // Marks that at least one cycle out of reset has passed
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2
    nan_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_vld) && $past(&in_op[FLT_W-2 -: EXP_W]) && $past(|in_op[MAN_W-1:0]))
        |-> (out_res == '0 && out_invalid));

    // R3
    neg_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_vld) && $past(in_op[FLT_W-1]) && $past(|in_op[FLT_W-2:0]))
        |-> (out_res == '0 && out_invalid && !out_inexact));

    // R4
    zero_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_vld) && $past(in_op[FLT_W-2:0] == '0))
        |-> (out_res == '0 && !out_invalid && !out_inexact));

    // R5
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_invalid && out_res != '0) |-> (&out_res));

    // R6
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_invalid && out_inexact));

    // R8
    clr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_clr == !(out_invalid || out_inexact)));

    // R9
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (out_vld == $past(in_vld)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(in_vld)) |-> ($stable(out_res) && $stable(out_invalid) && $stable(out_inexact)));

endmodule

bind f2u_trunc_conv f2u_trunc_conv_chk #(
    .EXP_W (EXP_W),
    .MAN_W (MAN_W),
    .INT_W (INT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_vld      (in_vld),
    .in_op       (in_op),
    .out_vld     (out_vld),
    .out_res     (out_res),
    .out_invalid (out_invalid),
    .out_inexact (out_inexact),
    .out_clr     (out_clr)
);

// File: tb/f2u_trunc_conv_test.sv
`timescale 1ns/1ps
module f2u_trunc_conv_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] in_op = '0;
    logic        out_vld;
    logic [31:0] out_res;
    logic        out_invalid;
    logic        out_inexact;
    logic        out_clr;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    f2u_trunc_conv uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_vld      (in_vld),
        .in_op       (in_op),
        .out_vld     (out_vld),
        .out_res     (out_res),
        .out_invalid (out_invalid),
        .out_inexact (out_inexact),
        .out_clr     (out_clr)
    );

    // Reference: returns {result, invalid, inexact}
    function automatic logic [33:0] model(input logic [31:0] x);
        logic         s;
        logic [7:0]   e;
        logic [22:0]  f;
        logic [191:0] big;
        logic [31:0]  r;
        s = x[31]; e = x[30:23]; f = x[22:0];
        if (e == 8'hFF && f != 0)  return {32'h0, 1'b1, 1'b0};
        if (x[30:0] == 0)          return {32'h0, 1'b0, 1'b0};
        if (s)                     return {32'h0, 1'b1, 1'b0};
        if (e == 8'hFF)            return {32'hFFFF_FFFF, 1'b1, 1'b0};
        if (e == 0)                return {32'h0, 1'b0, 1'b1};
        if (e >= 8'd159)           return {32'hFFFF_FFFF, 1'b1, 1'b0};
        big = 192'({1'b1, f}) << e;
        r   = big[181:150];
        return {r, 1'b0, (big[149:0] != 0)};
    endfunction

    task automatic note(input string req, input bit ok, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [31:0] x);
        if (x[30:23] == 8'hFF && x[22:0] != 0) return "R2";
        if (x[30:0] == 0)                      return "R4";
        if (x[31])                             return "R3";
        if (x[30:23] >= 8'd159)                return "R5";
        if (x[30:23] < 8'd127)                 return "R7";
        return "R1";
    endfunction

    // Apply one operand and check the registered outputs one cycle later
    task automatic apply(input logic [31:0] x);
        logic [33:0] m;
        string       rq;
        m  = model(x);
        rq = req_of(x);
        @(negedge clk);
        in_vld = 1'b1;
        in_op  = x;
        @(negedge clk);
        in_vld = 1'b0;
        note(rq, out_res == m[33:2], $sformatf("result op=%h", x), out_res, m[33:2]);
        note("R6", out_invalid == m[1], $sformatf("invalid op=%h", x), 32'(out_invalid), 32'(m[1]));
        note("R7", out_inexact == m[0], $sformatf("inexact op=%h", x), 32'(out_inexact), 32'(m[0]));
        note("R8", out_clr == !(m[1] | m[0]), $sformatf("clr op=%h", x), 32'(out_clr), 32'(!(m[1] | m[0])));
        note("R9", out_vld == 1'b1, "out_vld after strobe", 32'(out_vld), 32'd1);
    endtask

    initial begin
        logic [31:0] keep_res;
        logic        keep_inv;
        repeat (3) @(negedge clk);
        // R9: reset state
        note("R9", out_vld == 0 && out_res == 0 && out_invalid == 0 && out_inexact == 0 && out_clr == 0,
             "reset outputs", {out_res[27:0], out_vld, out_invalid, out_inexact, out_clr}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        apply(32'h836D_4E86);  // R3 tiny negative
        apply(32'h8000_0000);  // R4 negative zero
        apply(32'h0000_0000);  // R4
        apply(32'h7FC0_0000);  // R2 quiet NaN
        apply(32'h7F80_0001);  // R2 signalling NaN
        apply(32'hFFC0_0000);  // R2 negative NaN
        apply(32'h7F80_0000);  // R5 +inf
        apply(32'hFF80_0000);  // R3 -inf
        apply(32'h4F80_0000);  // R5 exactly 2^32
        apply(32'h4F7F_FFFF);  // R1 largest in range
        apply(32'h3F80_0000);  // R1 1.0
        apply(32'h3F7F_FFFF);  // R7 just below 1
        apply(32'h0000_0001);  // R7 smallest subnormal
        apply(32'h8000_0001);  // R3 negative subnormal
        apply(32'h4049_0FDB);  // R1 pi -> 3 inexact
        apply(32'h4B00_0001);  // R1 exact integer
        apply(32'hBF80_0000);  // R3 -1.0

        // R9: no strobe -> hold, out_vld low
        keep_res = out_res;
        keep_inv = out_invalid;
        @(negedge clk);
        in_op = 32'h4F80_0000;
        @(negedge clk);
        note("R9", out_vld == 1'b0, "out_vld without strobe", 32'(out_vld), 32'd0);
        note("R9", out_res == keep_res && out_invalid == keep_inv, "hold without strobe", out_res, keep_res);

        // Random operands across all exponents
        void'($urandom(32'd1234));
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] x;
            x = $urandom();
            x[30:23] = 8'($urandom_range(0, 255));
            if (i % 4 == 0) x[30:23] = 8'($urandom_range(120, 162));
            if (i % 16 == 1) x[22:0] = '0;
            apply(x);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_miss++;
            $display("FAIL R9 watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

endmodule